// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadow Set

This block is the integer register file of a core: 32 entries of 64 bits, two combinational read ports and one write port. It also holds a second, smaller bank of eight shadow registers. While the core runs privileged firmware, the shadow bank stands in for architectural registers 8 through 14 and register 25. The firmware can then use those registers as scratch space without saving the interrupted program's values. Every other register is the same physical entry in both modes.

The core sends a one-cycle enter strobe when it takes a trap into firmware and a one-cycle exit strobe when it returns. The block keeps the mode flag and steers each access to the right bank, so a mode change costs no copy cycles. A request that would not change the mode is flagged on an error output: entering while already privileged, leaving while not privileged, or asking for both at once. Register 31 is a hard zero.

At reset the file starts in privileged mode. Registers 0 and 16 are loaded with a core-identifier value, and every other entry is cleared, so each core's boot firmware finds its own number in two known places.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, `priv_mode` is 1 and `mode_err` is 0. Registers 0 and 16 read the value of `core_id`, and every other register reads zero in both banks.
- R2: Reading address 31 on either port returns zero, and a write to address 31 has no effect on any later read.
- R3: A write with `wr_en` high is visible on both read ports from the cycle after the clock edge that accepts it. Reads are combinational from the address.
- R4: While `priv_mode` is 1, addresses 8, 9, 10, 11, 12, 13, 14 and 25 read and write the shadow bank. A value written to one of them while `priv_mode` is 0 reads back unchanged after a round trip into and out of privileged mode.
- R5: All addresses other than 8–14, 25 and 31 access the same storage whatever the mode. A value written in one mode reads the same in the other.
- R6: `enter_req` alone while `priv_mode` is 0 sets `priv_mode` at that clock edge. `exit_req` alone while `priv_mode` is 1 clears it at that edge.
- R7: `enter_req` while `priv_mode` is 1, or `exit_req` while `priv_mode` is 0, leaves `priv_mode` unchanged. It drives `mode_err` high for exactly the following cycle.
- R8: `enter_req` and `exit_req` high in the same cycle leave `priv_mode` unchanged and drive `mode_err` high for the following cycle.
- R9: A write accepted on the same edge as a mode change goes to the bank selected by the new mode.
- R10: A value written to a shadowed address while `priv_mode` is 1 is hidden while `priv_mode` is 0, and reads back again after the next entry to privileged mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id | input | 64 | Core number loaded into registers 0 and 16 at reset |
| enter_req | input | 1 | Strobe: enter privileged mode |
| exit_req | input | 1 | Strobe: leave privileged mode |
| priv_mode | output | 1 | 1 while the shadow bank is selected |
| mode_err | output | 1 | One-cycle pulse after a request that does not change the mode |
| rd_a_addr | input | 5 | Read port A address |
| rd_a_data | output | 64 | Read port A data |
| rd_b_addr | input | 5 | Read port B address |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |

## Verification
Read data follows the address within the same cycle, so the bench checks reads one time unit after it changes an address. A write, a mode change and `mode_err` all take effect at the clock edge that samples the request. The bench therefore drives every request just after a rising edge and checks its result just after the next rising edge. The error pulse is checked at that one edge, and then checked low at the edge after it. This confirms that the pulse lasts a single cycle and that the mode did not move.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned NREGS     = 32;
  // Architectural registers replaced by the shadow bank in privileged mode.
  localparam logic [31:0] BANK_MASK = 32'h0200_7F00;
  // Registers loaded with the core identifier at reset.
  localparam int unsigned ID_REG_LO = 0;
  localparam int unsigned ID_REG_HI = 16;

  function automatic int unsigned count_set(input logic [31:0] m);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/srf_mode_ctrl.sv
module srf_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic exit_req,
  output logic priv_q,
  output logic priv_d,
  output logic err_q
);
  logic err_d;
  logic mode_en;

  always_comb begin
    priv_d  = priv_q;
    err_d   = 1'b0;
    mode_en = enter_req | exit_req;
    if (enter_req && exit_req) begin
      err_d = 1'b1;
    end else if (enter_req) begin
      if (priv_q) err_d = 1'b1;
      else        priv_d = 1'b1;
    end else if (exit_req) begin
      if (!priv_q) err_d = 1'b1;
      else         priv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) priv_q <= priv_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/srf_addr_map.sv
module srf_addr_map #(
  parameter int unsigned NUM_REGS  = 32,
  parameter logic [31:0] MASK      = 32'h0,
  parameter int unsigned AW        = 5,
  parameter int unsigned SW        = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          priv,
  output logic          is_zero,
  output logic          use_shadow,
  output logic [SW-1:0] slot
);
  localparam int unsigned ZERO_IDX = NUM_REGS - 1;

  always_comb begin
    is_zero    = (addr == AW'(ZERO_IDX));
    use_shadow = priv && MASK[addr];
    slot       = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (MASK[i] && (AW'(i) < addr)) slot = slot + SW'(1);
    end
  end
endmodule

// File: rtl/srf_storage.sv
module srf_storage #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned NUM_SHADOW = 8,
  parameter int unsigned AW         = 5,
  parameter int unsigned SW         = 3,
  parameter int unsigned ID_LO      = 0,
  parameter int unsigned ID_HI      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] core_id,
  input  logic              wr_main,
  input  logic              wr_shadow,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SW-1:0]     wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] main_q   [NUM_REGS],
  output logic [DATA_W-1:0] shadow_q [NUM_SHADOW]
);
  logic [DATA_W-1:0] main_d   [NUM_REGS];
  logic [DATA_W-1:0] shadow_d [NUM_SHADOW];
  logic [NUM_REGS-1:0]   main_en;
  logic [NUM_SHADOW-1:0] shadow_en;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      main_en[i] = wr_main && (wr_addr == AW'(i));
      main_d[i]  = wr_data;
    end
    for (int j = 0; j < NUM_SHADOW; j++) begin
      shadow_en[j] = wr_shadow && (wr_slot == SW'(j));
      shadow_d[j]  = wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_main
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        main_q[g] <= (g == ID_LO || g == ID_HI) ? core_id : '0;
      end else if (main_en[g]) begin
        main_q[g] <= main_d[g];
      end
    end
  end

  for (genvar s = 0; s < NUM_SHADOW; s++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[s] <= '0;
      end else if (shadow_en[s]) begin
        shadow_q[s] <= shadow_d[s];
      end
    end
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
#(
  parameter int unsigned DATA_W   = XLEN,
  parameter int unsigned NUM_REGS = NREGS,
  parameter logic [31:0] MASK     = BANK_MASK,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] core_id,
  input  logic              enter_req,
  input  logic              exit_req,
  output logic              priv_mode,
  output logic              mode_err,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned NUM_SHADOW = count_set(MASK);
  localparam int unsigned SW         = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1;
  localparam int unsigned NRD        = 2;

  logic priv_d;
  logic [DATA_W-1:0] main_q   [NUM_REGS];
  logic [DATA_W-1:0] shadow_q [NUM_SHADOW];

  srf_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .priv_q(priv_mode), .priv_d(priv_d), .err_q(mode_err)
  );

  // Write side: steered by the mode in force after this edge.
  logic          w_zero, w_shadow;
  logic [SW-1:0] w_slot;
  srf_addr_map #(.NUM_REGS(NUM_REGS), .MASK(MASK), .AW(AW), .SW(SW)) u_wmap (
    .addr(wr_addr), .priv(priv_d), .is_zero(w_zero),
    .use_shadow(w_shadow), .slot(w_slot)
  );

  srf_storage #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SHADOW(NUM_SHADOW),
    .AW(AW), .SW(SW), .ID_LO(ID_REG_LO), .ID_HI(ID_REG_HI)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .core_id(core_id),
    .wr_main(wr_en && !w_zero && !w_shadow),
    .wr_shadow(wr_en && !w_zero && w_shadow),
    .wr_addr(wr_addr), .wr_slot(w_slot), .wr_data(wr_data),
    .main_q(main_q), .shadow_q(shadow_q)
  );

  // Read side: one address decoder and mux per port.
  logic [AW-1:0]     r_addr [NRD];
  logic [DATA_W-1:0] r_data [NRD];
  assign r_addr[0] = rd_a_addr;
  assign r_addr[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          r_zero, r_shadow;
    logic [SW-1:0] r_slot;
    srf_addr_map #(.NUM_REGS(NUM_REGS), .MASK(MASK), .AW(AW), .SW(SW)) u_rmap (
      .addr(r_addr[p]), .priv(priv_mode), .is_zero(r_zero),
      .use_shadow(r_shadow), .slot(r_slot)
    );
    always_comb begin
      if (r_zero)        r_data[p] = '0;
      else if (r_shadow) r_data[p] = shadow_q[r_slot];
      else               r_data[p] = main_q[r_addr[p]];
    end
  end

  assign rd_a_data = r_data[0];
  assign rd_b_data = r_data[1];
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enter_req,
  input logic              exit_req,
  input logic              priv_mode,
  input logic              mode_err,
  input logic [AW-1:0]     rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [AW-1:0]     rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data
);
  localparam logic [AW-1:0] ZADDR = '1;

  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == ZADDR) |-> (rd_a_data == '0)); // R2
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == ZADDR) |-> (rd_b_data == '0)); // R2
  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && !exit_req && !priv_mode) |=> (priv_mode && !mode_err)); // R6
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !enter_req && priv_mode) |=> (!priv_mode && !mode_err)); // R6
  AST_REDUNDANT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((enter_req && !exit_req && priv_mode) || (exit_req && !enter_req && !priv_mode))
    |=> (mode_err && $stable(priv_mode))); // R7
  AST_BOTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && exit_req) |=> (mode_err && $stable(priv_mode))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_req && !exit_req) |=> (!mode_err && $stable(priv_mode))); // R7
endmodule

bind shadow_regfile srf_checker #(.DATA_W(DATA_W), .AW(AW)) u_srf_chk (
  .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
  .priv_mode(priv_mode), .mode_err(mode_err),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
);

// File: tb/shadow_regfile_bench.sv
module shadow_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CORE_ID = 64'h0000_0000_0000_0005;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enter_req, exit_req, wr_en;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [63:0] wr_data, rd_a_data, rd_b_data;
  logic        priv_mode, mode_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_regfile u_shadow_regfile (
    .clk(clk), .rst_n(rst_n), .core_id(CORE_ID),
    .enter_req(enter_req), .exit_req(exit_req),
    .priv_mode(priv_mode), .mode_err(mode_err),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Advance one edge; return just after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [63:0] exp);
    rd_a_addr = a;
    rd_b_addr = a;
    #1;
    chk({tag, " port A"}, rd_a_data, exp);
    chk({tag, " port B"}, rd_b_data, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic req(input logic en, input logic ex);
    enter_req = en; exit_req = ex;
    tick();
    enter_req = 1'b0; exit_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 priv after reset", {63'd0, priv_mode}, 64'd1);
    chk("R1 err after reset", {63'd0, mode_err}, 64'd0);
    rd("R1 r0 id", 5'd0, CORE_ID);
    rd("R1 r16 id", 5'd16, CORE_ID);
    rd("R1 r5 zero", 5'd5, 64'd0);
    rd("R1 r9 shadow zero", 5'd9, 64'd0);
  endtask

  task automatic t_zero_reg();
    wr(5'd31, 64'hDEAD_BEEF_0000_1111);
    rd("R2 r31 after write", 5'd31, 64'd0);
  endtask

  task automatic t_write_read();
    wr(5'd3, 64'h1111_2222_3333_4444);
    rd("R3 r3 readback", 5'd3, 64'h1111_2222_3333_4444);
    wr(5'd20, 64'hA5A5_A5A5_0000_0001);
    rd("R3 r20 readback", 5'd20, 64'hA5A5_A5A5_0000_0001);
  endtask

  task automatic t_switch_and_round_trip();
    req(1'b0, 1'b1);
    chk("R6 exit clears priv", {63'd0, priv_mode}, 64'd0);
    chk("R6 exit no err", {63'd0, mode_err}, 64'd0);
    rd("R1 r0 id normal", 5'd0, CORE_ID);
    wr(5'd9,  64'h0000_0000_0000_0A09);
    wr(5'd25, 64'h0000_0000_0000_0B25);
    wr(5'd3,  64'h0000_0000_0000_0C03);
    req(1'b1, 1'b0);
    chk("R6 enter sets priv", {63'd0, priv_mode}, 64'd1);
    rd("R4 r9 shadow in priv", 5'd9, 64'd0);
    rd("R5 r3 same in priv", 5'd3, 64'h0000_0000_0000_0C03);
    wr(5'd9, 64'h0000_0000_0000_0D09);
    wr(5'd4, 64'h0000_0000_0000_0E04);
    req(1'b0, 1'b1);
    rd("R4 r9 restored", 5'd9, 64'h0000_0000_0000_0A09);
    rd("R4 r25 restored", 5'd25, 64'h0000_0000_0000_0B25);
    rd("R5 r4 visible normal", 5'd4, 64'h0000_0000_0000_0E04);
    req(1'b1, 1'b0);
    rd("R10 r9 shadow kept", 5'd9, 64'h0000_0000_0000_0D09);
  endtask

  task automatic t_redundant();
    // now privileged
    req(1'b1, 1'b0);
    chk("R7 enter in priv err", {63'd0, mode_err}, 64'd1);
    chk("R7 enter in priv mode kept", {63'd0, priv_mode}, 64'd1);
    tick();
    chk("R7 err one cycle", {63'd0, mode_err}, 64'd0);
    req(1'b0, 1'b1);
    req(1'b0, 1'b1);
    chk("R7 exit in normal err", {63'd0, mode_err}, 64'd1);
    chk("R7 exit in normal mode kept", {63'd0, priv_mode}, 64'd0);
    tick();
    chk("R7 err cleared", {63'd0, mode_err}, 64'd0);
  endtask

  task automatic t_both();
    // now normal
    req(1'b1, 1'b1);
    chk("R8 both err", {63'd0, mode_err}, 64'd1);
    chk("R8 both mode kept", {63'd0, priv_mode}, 64'd0);
  endtask

  task automatic t_same_cycle();
    // normal mode: r10 holds 0 in the normal bank
    enter_req = 1'b1; wr_en = 1'b1; wr_addr = 5'd10; wr_data = 64'h0000_0000_0000_0F10;
    tick();
    enter_req = 1'b0; wr_en = 1'b0;
    rd("R9 r10 in new bank", 5'd10, 64'h0000_0000_0000_0F10);
    exit_req = 1'b1; wr_en = 1'b1; wr_addr = 5'd11; wr_data = 64'h0000_0000_0000_0F11;
    tick();
    exit_req = 1'b0; wr_en = 1'b0;
    rd("R9 r10 normal untouched", 5'd10, 64'd0);
    rd("R9 r11 to normal bank", 5'd11, 64'h0000_0000_0000_0F11);
    req(1'b1, 1'b0);
    rd("R10 r10 shadow kept", 5'd10, 64'h0000_0000_0000_0F10);
    rd("R9 r11 shadow untouched", 5'd11, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enter_req = 1'b0; exit_req = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_a_addr = '0; rd_b_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 priv during reset", {63'd0, priv_mode}, 64'd1);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_zero_reg();
    t_write_read();
    t_switch_and_round_trip();
    t_redundant();
    t_both();
    t_same_cycle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule